// File: doc/BRIEF.md
# Boot Stream Loader

This block sits behind a byte-level serial memory reader that packs the bytes it fetches into 16-bit words, low byte first. It accepts those words through a valid/ready handshake and first reads a fixed header. The header holds a width key, the serial clock prescaler, the high and low counts of the serial clock, a run of skipped and reserved words, and a 32-bit start address split across two words.

After the header comes a sequence of load blocks. Each block has a word count, a 32-bit destination address sent as two words, and then that many data words. Every data word becomes one write on the memory port, to consecutive addresses. A count of zero ends the stream. The block then raises `done` and shows the start address. A wrong width key raises `error` and stops all further intake.

Top module: `boot_stream_parser`

## Requirements
- R1: After reset, `done`, `error` and `mem_we` are 0, `in_ready` is 1, and `entry_point` reads 0.
- R2: If the first accepted word is not `KEY` (default 0x08AA), `error` goes to 1 after that handshake. It stays at 1, and `done` stays at 0.
- R3: In the second header word, bits [7:0] are captured on `prescale`. Bits [15:8] have no effect on any output.
- R4: The third header word appears on `scl_high` and the fourth on `scl_low`.
- R5: The next `SKIP_WORDS` words (default 4) and the reserved word after them have no effect on any output.
- R6: The next two words form the start address as {upper, lower}. `entry_point` reads 0 while `done` is 0 and holds the address once `done` is 1.
- R7: Each load block is made of a count word N, an address upper word, an address lower word, and then N data words. Data word i is written one cycle after its handshake, with `mem_we`=1, `mem_addr` = base + i and `mem_data` = that word. The address increments across the 16-bit boundary.
- R8: A count word of 0 sets `done` to 1 after its handshake. It causes no write, even when it directly follows the header.
- R9: Cycles with `in_valid` low do not advance the parse and do not change the written results.
- R10: Once `done` or `error` is 1, `in_ready` is 0 and further words cause no write and no change to any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can take a word |
| in_data | input | 16 | Stream word, low byte in [7:0] |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_data | output | 16 | Memory write data |
| prescale | output | 8 | Captured prescaler |
| scl_high | output | 16 | Captured clock high count |
| scl_low | output | 16 | Captured clock low count |
| entry_point | output | 32 | Start address, valid with `done` |
| done | output | 1 | Stream ended normally |
| error | output | 1 | Width key mismatch |

## Verification
The bench builds the block with its defaults: `KEY` = 0x08AA, `SKIP_WORDS` = 4 and `AW` = 32. With these values the full eleven-word header is exercised, including the four skipped words and the reserved word, each loaded with non-zero values that would show up if the word count were off by one. The 32-bit address lets a block start at 0x0001FFFE, so the write address carries out of the lower half. The tests also feed a swapped-byte key to confirm the byte order is checked.

// File: rtl/boot_stream_parser.sv
module boot_stream_parser #(
  parameter logic [15:0] KEY        = 16'h08AA,
  parameter int          SKIP_WORDS = 4,
  parameter int          AW         = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [15:0]   in_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_data,
  output logic [7:0]    prescale,
  output logic [15:0]   scl_high,
  output logic [15:0]   scl_low,
  output logic [31:0]   entry_point,
  output logic          done,
  output logic          error
);
  localparam int IDX_EHI = 5 + SKIP_WORDS;
  localparam int IDX_ELO = 6 + SKIP_WORDS;
  localparam int HW      = $clog2(IDX_ELO + 1);

  typedef enum logic [2:0] {S_HDR, S_SIZE, S_AHI, S_ALO, S_DATA, S_DONE, S_ERR} st_t;

  st_t           st;
  logic [HW-1:0] idx;
  logic [15:0]   remain;
  logic [15:0]   addr_hi;
  logic [AW-1:0] wr_addr;
  logic [31:0]   entry_q;
  logic [31:0]   full_addr;
  logic          take;

  assign in_ready    = (st != S_DONE) && (st != S_ERR);
  assign take        = in_valid && in_ready;
  assign done        = (st == S_DONE);
  assign error       = (st == S_ERR);
  assign entry_point = done ? entry_q : 32'd0;
  assign full_addr   = {addr_hi, in_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_HDR;
      idx      <= '0;
      remain   <= '0;
      addr_hi  <= '0;
      wr_addr  <= '0;
      entry_q  <= '0;
      prescale <= '0;
      scl_high <= '0;
      scl_low  <= '0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      mem_we <= 1'b0;
      if (take) begin
        case (st)
          S_HDR: begin
            idx <= idx + 1'b1;
            if (idx == HW'(0)) begin
              if (in_data != KEY) st <= S_ERR;
            end else if (idx == HW'(1)) prescale <= in_data[7:0];
            else if (idx == HW'(2)) scl_high <= in_data;
            else if (idx == HW'(3)) scl_low <= in_data;
            else if (idx == HW'(IDX_EHI)) entry_q[31:16] <= in_data;
            else if (idx == HW'(IDX_ELO)) begin
              entry_q[15:0] <= in_data;
              st            <= S_SIZE;
            end
          end
          S_SIZE: begin
            if (in_data == 16'd0) st <= S_DONE;
            else begin
              remain <= in_data;
              st     <= S_AHI;
            end
          end
          S_AHI: begin
            addr_hi <= in_data;
            st      <= S_ALO;
          end
          S_ALO: begin
            wr_addr <= full_addr[AW-1:0];
            st      <= S_DATA;
          end
          S_DATA: begin
            mem_we   <= 1'b1;
            mem_addr <= wr_addr;
            mem_data <= in_data;
            wr_addr  <= wr_addr + 1'b1;
            remain   <= remain - 1'b1;
            if (remain == 16'd1) st <= S_SIZE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/boot_stream_parser_chk.sv
module boot_stream_parser_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   entry_point,
  input logic          done,
  input logic          error
);
  AST_WE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(in_valid && in_ready)); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R8
  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> (error && !done)); // R2
  AST_IDLE_WHEN_FINISHED: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> !in_ready); // R10
  AST_NO_WRITE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> !mem_we); // R10
  AST_ENTRY_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (entry_point == 32'd0)); // R6
endmodule

bind boot_stream_parser boot_stream_parser_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .entry_point(entry_point),
  .done(done), .error(error)
);

// File: tb/boot_stream_parser_bench.sv
module boot_stream_parser_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_data;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [15:0] mem_data;
  logic [7:0]  prescale;
  logic [15:0] scl_high, scl_low;
  logic [31:0] entry_point;
  logic        done, error;

  int checks = 0;
  int errors = 0;
  int nw = 0;
  logic [31:0] wa [0:15];
  logic [15:0] wd [0:15];

  always #2 clk = ~clk;

  boot_stream_parser u_boot_stream_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .prescale(prescale), .scl_high(scl_high), .scl_low(scl_low),
    .entry_point(entry_point), .done(done), .error(error)
  );

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (nw < 16) begin
        wa[nw] = mem_addr;
        wd[nw] = mem_data;
      end
      nw = nw + 1;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    in_data  = 16'h0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nw    = 0;
    @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 16'hA5A5 ^ 16'(i);
    end
  endtask

  task automatic send_header();
    send_word(16'h08AA);
    send_word(16'hC35A);
    send_word(16'h1234);
    idle(2);
    send_word(16'h0ABC);
    for (int i = 0; i < 4; i++) send_word(16'hFFF0 | 16'(i));
    send_word(16'hDEAD);
    send_word(16'h0033);
    send_word(16'h7788);
  endtask

  task automatic t_reset_state();
    do_reset();
    check(!done && !error, "R1 done/error", {30'd0, done, error}, 32'd0);
    check(!mem_we, "R1 mem_we", {31'd0, mem_we}, 32'd0);
    check(in_ready, "R1 in_ready", {31'd0, in_ready}, 32'd1);
    check(entry_point == 0, "R1 entry_point", entry_point, 32'd0);
  endtask

  task automatic t_bad_key(input logic [15:0] key);
    do_reset();
    send_word(key);
    idle(1);
    check(error, "R2 error after bad key", {31'd0, error}, 32'd1);
    check(!done, "R2 done stays low", {31'd0, done}, 32'd0);
    check(!in_ready, "R10 ready low after error", {31'd0, in_ready}, 32'd0);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = (i == 0) ? 16'h08AA : 16'h0001;
    end
    idle(2);
    check(nw == 0, "R10 no writes after error", nw, 32'd0);
    check(error && !done, "R2 error sticky", {30'd0, done, error}, 32'd1);
    check(prescale == 0 && scl_high == 0, "R10 outputs unchanged after error", {8'd0, prescale, scl_high}, 32'd0);
  endtask

  task automatic t_full_stream();
    do_reset();
    send_header();
    idle(1);
    check(prescale == 8'h5A, "R3 prescale low byte", {24'd0, prescale}, 32'h5A);
    check(scl_high == 16'h1234, "R4 scl_high", {16'd0, scl_high}, 32'h1234);
    check(scl_low == 16'h0ABC, "R4 scl_low", {16'd0, scl_low}, 32'h0ABC);
    check(!done && !error, "R5 skipped words keep parse going", {30'd0, done, error}, 32'd0);
    check(entry_point == 0, "R6 entry hidden before done", entry_point, 32'd0);
    send_word(16'd3); send_word(16'h0001); idle(3); send_word(16'hFFFE);
    send_word(16'h1111); send_word(16'h2222); idle(2); send_word(16'h3333);
    send_word(16'd1); send_word(16'h0000); send_word(16'h0010); send_word(16'hBEEF);
    idle(2);
    check(nw == 4, "R7 write count", nw, 32'd4);
    check(wa[0] == 32'h0001FFFE && wd[0] == 16'h1111, "R7 write 0", wa[0], 32'h0001FFFE);
    check(wa[1] == 32'h0001FFFF && wd[1] == 16'h2222, "R7 write 1", wa[1], 32'h0001FFFF);
    check(wa[2] == 32'h00020000 && wd[2] == 16'h3333, "R7 carry across halves", wa[2], 32'h00020000);
    check(wa[3] == 32'h00000010 && wd[3] == 16'hBEEF, "R9 second block after gaps", wa[3], 32'h00000010);
    check(!done, "R8 not done before zero count", {31'd0, done}, 32'd0);
    send_word(16'd0);
    idle(1);
    check(done && !error, "R8 done after zero count", {30'd0, done, error}, 32'h2);
    check(entry_point == 32'h00337788, "R6 entry point", entry_point, 32'h00337788);
    check(!in_ready, "R10 ready low after done", {31'd0, in_ready}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 16'h0004 + 16'(i);
    end
    idle(2);
    check(nw == 4, "R10 no writes after done", nw, 32'd4);
    check(done && entry_point == 32'h00337788 && prescale == 8'h5A, "R10 outputs hold", entry_point, 32'h00337788);
  endtask

  task automatic t_empty_stream();
    do_reset();
    send_header();
    send_word(16'd0);
    idle(2);
    check(done, "R8 zero count right after header", {31'd0, done}, 32'd1);
    check(nw == 0, "R8 no write on zero count", nw, 32'd0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_bad_key(16'h08AB);
    t_bad_key(16'hAA08);
    t_full_stream();
    t_empty_stream();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule